// File: doc/BRIEF.md
# Restoring Sequential Unsigned Divider

This block divides a 32-bit unsigned dividend by a 32-bit unsigned divisor. It works one quotient bit per clock with the restoring method. At the start the divisor is captured in its own register. A 64-bit working register, widened by one extension bit, holds the partial remainder in its upper half and collects quotient bits in its lower half. Each step makes a trial subtraction of the divisor from the upper half. A borrow keeps the old upper half. In both cases the register then shifts left by one place and the new quotient bit enters at the bottom. After the last step, the upper half is shifted right by one place to give the true remainder.

A request is a one-cycle `start_i` pulse while the block is idle. `busy_o` stays high while the operation runs. `done_o` pulses for one cycle when the quotient and remainder outputs are updated, and the outputs then hold until the next result. A zero divisor skips the iteration loop. It raises a flag and returns a fixed result.

Top module: `rsdiv_top`

## Requirements
- R1: While reset is held, busy_o, done_o and div_zero_o are 0 and quotient_o and remainder_o are all zeros.
- R2: For a nonzero divisor, quotient_o equals the floor of dividend/divisor and remainder_o equals dividend minus quotient times divisor, for every unsigned 32-bit operand, including divisors at or above 2^31.
- R3: For a nonzero divisor, done_o is high for exactly one cycle. That cycle comes 34 rising edges after the edge that samples start_i (1 loading edge, 32 iteration edges, 1 result edge).
- R4: busy_o rises on the edge that samples an accepted start_i, stays high until the result edge, and is 0 whenever done_o is 1.
- R5: A start_i pulse or a change of the operand inputs while busy_o is 1 has no effect. The running operation returns the result for the operands sampled at its own start, and no extra done_o pulse follows.
- R6: A divisor of zero sets div_zero_o to 1, returns quotient all ones and remainder equal to the dividend, and pulses done_o 2 rising edges after the edge that samples start_i.
- R7: div_zero_o is updated with each result, so a division by a nonzero divisor after a division by zero reports div_zero_o = 0.
- R8: quotient_o, remainder_o and div_zero_o change only on the edge that raises done_o, and hold their values in every other cycle.
- R9: Whenever done_o is 1 with div_zero_o = 0, remainder_o is strictly less than the divisor of that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only while idle |
| dividend_i | input | 32 | Unsigned dividend, sampled with start_i |
| divisor_i | input | 32 | Unsigned divisor, sampled with start_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: new result on the outputs |
| quotient_o | output | 32 | Quotient of the last operation |
| remainder_o | output | 32 | Remainder of the last operation |
| div_zero_o | output | 1 | Last operation had a zero divisor |

## Verification
The bound checker watches properties that hold on every cycle. done_o is a single-cycle pulse and never coincides with busy_o. An accepted start always raises busy_o. The outputs never move outside a done cycle. A reported remainder is always below the captured divisor. A zero-divisor result always carries an all-ones quotient. Only the bench's scenarios can show the rest: the arithmetic itself across extreme and pseudo-random operands, the exact 34-cycle and 2-cycle latencies, the clearing of the zero flag, and that a start pulse or operand change during a running operation is ignored.

// File: rtl/rsdiv_pkg.sv
package rsdiv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

endpackage

// File: rtl/rsdiv_step.sv
// One restoring iteration: trial subtraction, keep or restore, shift left.
module rsdiv_step #(
    parameter int W = 32
) (
    input  logic         ext_i,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    input  logic [W-1:0] dvs_i,
    output logic         ext_o,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o
);
    localparam int DW = W + 2;

    logic [DW-1:0] diff;
    logic          neg;
    logic [W-1:0]  kept;

    always_comb begin
        diff = {1'b0, ext_i, left_i} - {2'b00, dvs_i};
        // Borrow marks a failed trial. The partial value is below twice the
        // divisor, so a kept difference always fits in W bits.
        neg  = diff[DW-1] | diff[DW-2];
        kept = neg ? left_i : diff[W-1:0];
        ext_o   = kept[W-1];
        left_o  = {kept[W-2:0], right_i[W-1]};
        right_o = {right_i[W-2:0], ~neg};
    end

endmodule

// File: rtl/rsdiv_counter.sv
// Iteration counter: cleared at load, advanced once per iteration.
module rsdiv_counter #(
    parameter int STEPS = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic adv_i,
    output logic last_o
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(STEPS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == LAST_V);

endmodule

// File: rtl/rsdiv_top.sv
module rsdiv_top #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o,
    output logic         div_zero_o
);
    import rsdiv_pkg::*;

    typedef struct packed {
        phase_e       phase;
        logic         zero;
        logic         ext;
        logic [W-1:0] left;
        logic [W-1:0] right;
        logic [W-1:0] dvs;
        logic [W-1:0] quo;
        logic [W-1:0] rem;
        logic         dbz;
        logic         done;
    } div_st_t;

    div_st_t st_d, st_q;

    logic         clr_cnt, adv_cnt, last_step;
    logic         step_ext;
    logic [W-1:0] step_left, step_right;
    logic [W-1:0] dvs_q;

    assign dvs_q = st_q.dvs;

    rsdiv_step #(.W(W)) step_i (
        .ext_i   (st_q.ext),
        .left_i  (st_q.left),
        .right_i (st_q.right),
        .dvs_i   (dvs_q),
        .ext_o   (step_ext),
        .left_o  (step_left),
        .right_o (step_right)
    );

    rsdiv_counter #(.STEPS(W)) cnt_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clr_cnt),
        .adv_i   (adv_cnt),
        .last_o  (last_step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_cnt   = 1'b0;
        adv_cnt   = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    clr_cnt  = 1'b1;
                    st_d.dvs = divisor_i;
                    st_d.ext = 1'b0;
                    if (divisor_i == '0) begin
                        st_d.zero  = 1'b1;
                        st_d.left  = dividend_i;
                        st_d.right = '1;
                        st_d.phase = PH_FIN;
                    end else begin
                        // load with the initial one-place left shift applied
                        st_d.zero  = 1'b0;
                        st_d.left  = {{(W-1){1'b0}}, dividend_i[W-1]};
                        st_d.right = {dividend_i[W-2:0], 1'b0};
                        st_d.phase = PH_RUN;
                    end
                end
            end
            PH_RUN: begin
                adv_cnt    = 1'b1;
                st_d.ext   = step_ext;
                st_d.left  = step_left;
                st_d.right = step_right;
                if (last_step) begin
                    st_d.phase = PH_FIN;
                end
            end
            PH_FIN: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.dbz   = st_q.zero;
                st_d.quo   = st_q.right;
                // undo the extra shift of the upper half
                st_d.rem   = st_q.zero ? st_q.left : {st_q.ext, st_q.left[W-1:1]};
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = (st_q.phase != PH_IDLE);
    assign done_o      = st_q.done;
    assign quotient_o  = st_q.quo;
    assign remainder_o = st_q.rem;
    assign div_zero_o  = st_q.dbz;

endmodule

// File: rtl/rsdiv_chk.sv
module rsdiv_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         dbz,
    input logic [W-1:0] quo,
    input logic [W-1:0] rem,
    input logic [W-1:0] dvs
);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_rem_below_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dbz) |-> (rem < dvs));

    p_zero_quo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dbz) |-> (quo == '1));

    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(rem) && $stable(dbz)));

endmodule

bind rsdiv_top rsdiv_chk #(.W(W)) chk_i (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .start (start_i),
    .busy  (busy_o),
    .done  (done_o),
    .dbz   (div_zero_o),
    .quo   (quotient_o),
    .rem   (remainder_o),
    .dvs   (dvs_q)
);

// File: tb/rsdiv_top_tb_top.sv
`timescale 1ns/1ps
module rsdiv_top_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, dzero;
    logic [W-1:0] quo, rem;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         z;
        int           t0;
        int           lat;
    } item_t;

    item_t sb_q[$];
    logic [W-1:0] last_q, last_r;
    logic         last_z;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rsdiv_top #(.W(W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .dividend_i  (dividend),
        .divisor_i   (divisor),
        .busy_o      (busy),
        .done_o      (done),
        .quotient_o  (quo),
        .remainder_o (rem),
        .div_zero_o  (dzero)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: issues one division, records the expected result in the scoreboard.
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
        item_t it;
        @(negedge clk);
        it.a = a; it.b = b;
        it.z = (b == '0);
        it.q = it.z ? '1 : a / b;
        it.r = it.z ? a : a % b;
        it.t0 = cyc;
        it.lat = it.z ? 2 : 34;
        sb_q.push_back(it);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R4", "busy after start", 64'(busy), 64'd1);
        if (disturb && !it.z) begin
            repeat (3) @(negedge clk);
            dividend = ~a; divisor = 32'd3; start = 1'b1;   // R5: must be ignored
            @(negedge clk);
            start = 1'b0;
            dividend = 32'hDEAD_BEEF; divisor = 32'd1;
        end
        while (busy) @(negedge clk);
        check(done === 1'b1, "R4", "done as busy falls", 64'(done), 64'd1);
        repeat (3) @(negedge clk);
        check(quo === it.q && rem === it.r && dzero === it.z, "R8", "outputs held",
              {quo, rem}, {it.q, it.r});
        check(done === 1'b0, "R5", "no extra done", 64'(done), 64'd0);
    endtask

    // Monitor: pops the expected item on every done pulse and compares.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5", "unexpected done", 64'd1, 64'd0);
            end else begin
                item_t e;
                e = sb_q.pop_front();
                check(quo === e.q, e.z ? "R6" : "R2", "quotient", 64'(quo), 64'(e.q));
                check(rem === e.r, e.z ? "R6" : "R2", "remainder", 64'(rem), 64'(e.r));
                check(dzero === e.z, e.z ? "R6" : "R7", "zero flag", 64'(dzero), 64'(e.z));
                check((cyc - e.t0) == e.lat, e.z ? "R6" : "R3", "latency",
                      64'(cyc - e.t0), 64'(e.lat));
                if (!e.z) begin
                    check(({32'b0, quo} * {32'b0, e.b} + {32'b0, rem}) == {32'b0, e.a},
                          "R2", "q*d+r identity",
                          {32'b0, quo} * {32'b0, e.b} + {32'b0, rem}, {32'b0, e.a});
                    check(rem < e.b, "R9", "remainder below divisor", 64'(rem), 64'(e.b));
                end
                last_q = quo; last_r = rem; last_z = dzero;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && dzero === 1'b0, "R1", "control in reset",
              {61'b0, busy, done, dzero}, 64'd0);
        check(quo === '0 && rem === '0, "R1", "data in reset", {quo, rem}, 64'd0);
        rst_n = 1'b1;

        run_div(32'd100, 32'd7, 1'b0);
        run_div(32'd0, 32'd5, 1'b0);
        run_div(32'd5, 32'd7, 1'b0);
        run_div(32'hFFFF_FFFF, 32'd1, 1'b0);
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_div(32'hFFFF_FFFF, 32'h8000_0001, 1'b0);
        run_div(32'hFFFF_FFFE, 32'h8000_0000, 1'b0);
        run_div(32'h1234_5678, 32'd0, 1'b0);
        run_div(32'd1000, 32'd10, 1'b0);
        run_div(32'd0, 32'd0, 1'b0);
        run_div(32'd7, 32'd7, 1'b1);
        run_div(32'hCAFE_F00D, 32'd12345, 1'b1);

        begin
            logic [W-1:0] s = 32'h1357_9BDF;
            for (int i = 0; i < 24; i++) begin
                logic [W-1:0] a, b;
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                a = s;
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                b = s >> s[4:0];
                run_div(a, b, i[0]);
            end
        end

        check(sb_q.size() == 0, "R3", "all results delivered", 64'(sb_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 64'(cyc), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule